// File: doc/BRIEF.md
# Multi-Mode DMA Channel Priority Arbiter

This block picks which DMA channel is served next. Each channel raises a request line. A two-bit mode field selects one of three fixed priority rankings or a two-tier rotating scheme. The winner receives a registered one-hot grant together with a valid flag. The grant stays in place until the channel's transfer logic pulses the end-of-grant input. One cycle after that pulse, the block arbitrates again.

A count input states how many channels are actually built. Request lines at or above that count are masked off and never win. A global enable gates the issue of new grants, so no channel is picked while DMA is switched off.

The control is a two-state machine:

- **IDLE**: arbitrating. The transition `IDLE -> HOLD` ("issue") is taken when the enable is set and at least one live request exists.
- **HOLD**: a grant is outstanding. The transition `HOLD -> IDLE` ("release") is taken on the end-of-grant pulse.
- Every other case keeps the current state.

In rotating mode, channels are split into groups of four, and each group keeps its own rotation pointer.

Top module: `dma_prio_arb`

## Requirements
- R1: With mode 0 (`2'b00`), the requesting live channel with the lowest index wins: 0, 1, 2, 3, 4, 5, 6, 7.
- R2: With mode 1 (`2'b01`), the ranking from highest to lowest is 0, 2, 3, 1, 4, 6, 7, 5.
- R3: With mode 2 (`2'b10`), the ranking from highest to lowest is 2, 0, 1, 3, 6, 4, 5, 7.
- R4: With mode 3 (`2'b11`), any live request among channels 0 to 3 beats every request among channels 4 to 7.
- R5: In mode 3, each group of four holds a pointer. The first requesting channel at or after the pointer (wrapping within the group) wins. After a grant in a group, that group's pointer moves to the channel just after the winner. Grants in modes 0 to 2 leave the pointers untouched.
- R6: A channel whose index is not below `n_present` is never granted, in any mode.
- R7: While `en` is low, no new grant is issued.
- R8: While a grant is outstanding and `grant_done` is low, `grant_vld` stays high and `grant` stays unchanged, even if requests, mode or `en` change.
- R9: A grant issued on a clock edge is visible after that edge. After the edge at which `grant_done` is high during a grant, `grant_vld` is low for exactly one cycle, and arbitration takes place on the following edge.
- R10: When no live channel requests, `grant_vld` is low and `grant` is all zeros.
- R11: After reset, `grant_vld` and `grant` are zero, and both rotation pointers point at the lowest channel of their group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global DMA enable; gates new grants |
| mode | input | 2 | Priority mode: 0, 1 and 2 are fixed rankings, 3 is two-tier rotation |
| req | input | NUM_CH | Per-channel request lines, bit i for channel i |
| n_present | input | $clog2(NUM_CH+1) | Number of channels that exist (6 in normal use) |
| grant_done | input | 1 | End-of-grant pulse from the served channel |
| grant | output | NUM_CH | One-hot grant, bit i for channel i |
| grant_vld | output | 1 | A grant is outstanding |

## Verification
Two functions can meet in one cycle: the release of an outstanding grant, and a new request that would win the next arbitration. The bench keeps a higher-ranked request asserted while a lower-ranked channel holds the grant. It first checks that the held grant does not move. It then pulses `grant_done` while that request is still present, and expects exactly one idle cycle followed by a grant to the new channel. A second kind of overlap is a held grant while `en` falls. The bench checks that the grant survives this.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int GROUP_SZ = 4;

    typedef enum logic [1:0] {
        MODE_LINEAR = 2'd0,
        MODE_PERM_A = 2'd1,
        MODE_PERM_B = 2'd2,
        MODE_ROTATE = 2'd3
    } arb_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

    // Channel that sits at a given rank (0 = highest) for a fixed mode.
    // Rankings repeat the same permutation inside every group of four.
    function automatic int unsigned rank_to_ch(input logic [1:0] mode,
                                               input int unsigned rank);
        int unsigned grp;
        int unsigned pos;
        int unsigned sub;
        grp = rank / GROUP_SZ;
        pos = rank % GROUP_SZ;
        case (mode)
            2'd1: begin
                case (pos)
                    0:       sub = 0;
                    1:       sub = 2;
                    2:       sub = 3;
                    default: sub = 1;
                endcase
            end
            2'd2: begin
                case (pos)
                    0:       sub = 2;
                    1:       sub = 0;
                    2:       sub = 1;
                    default: sub = 3;
                endcase
            end
            default: sub = pos;
        endcase
        return grp * GROUP_SZ + sub;
    endfunction

endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [1:0]        mode,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    // Scan from lowest rank upward so the highest-ranked request is kept last.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NUM_CH - 1; r >= 0; r--) begin
            int unsigned ch;
            ch = rank_to_ch(mode, r);
            if (req[ch]) begin
                hit = 1'b1;
                idx = IDX_W'(ch);
            end
        end
    end

endmodule

// File: rtl/arb_rr_group.sv
module arb_rr_group #(
    parameter int GRP = 4,
    parameter int PW  = $clog2(GRP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [GRP-1:0] req,
    input  logic           advance,
    output logic           hit,
    output logic [PW-1:0]  sel
);

    logic [PW-1:0] ptr_q;

    // First requester at or after the pointer, wrapping inside the group.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int k = GRP - 1; k >= 0; k--) begin
            logic [PW-1:0] cand;
            cand = ptr_q + PW'(k);
            if (req[cand]) begin
                hit = 1'b1;
                sel = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= sel + PW'(1);
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [1:0]                  mode,
    input  logic [NUM_CH-1:0]           req,
    input  logic [$clog2(NUM_CH+1)-1:0] n_present,
    input  logic                        grant_done,
    output logic [NUM_CH-1:0]           grant,
    output logic                        grant_vld
);

    localparam int IDX_W   = $clog2(NUM_CH);
    localparam int CNT_W   = $clog2(NUM_CH + 1);
    localparam int NUM_GRP = NUM_CH / GROUP_SZ;
    localparam int PW      = $clog2(GROUP_SZ);
    localparam int GW      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    arb_state_e        state_q, state_d;
    logic [NUM_CH-1:0] live;
    logic              fix_hit;
    logic [IDX_W-1:0]  fix_idx;
    logic [NUM_GRP-1:0] grp_hit;
    logic [PW-1:0]     grp_sel [NUM_GRP];
    logic              rr_hit;
    logic [IDX_W-1:0]  rr_idx;
    logic [GW-1:0]     win_grp;
    logic              cand_hit;
    logic [IDX_W-1:0]  cand_idx;
    logic              rot_mode;
    logic              issue;
    logic [NUM_CH-1:0] grant_q;

    // Mask off channels that are not built.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_live
        assign live[i] = req[i] && (CNT_W'(i) < n_present);
    end

    arb_fixed_pick #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_fixed (
        .req  (live),
        .mode (mode),
        .hit  (fix_hit),
        .idx  (fix_idx)
    );

    assign rot_mode = (arb_mode_e'(mode) == MODE_ROTATE);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        arb_rr_group #(
            .GRP (GROUP_SZ),
            .PW  (PW)
        ) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (live[g*GROUP_SZ +: GROUP_SZ]),
            .advance (issue && rot_mode && (win_grp == GW'(g))),
            .hit     (grp_hit[g]),
            .sel     (grp_sel[g])
        );
    end

    // Lower-numbered group always wins among rotating groups.
    always_comb begin
        rr_hit  = 1'b0;
        rr_idx  = '0;
        win_grp = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (grp_hit[g]) begin
                rr_hit  = 1'b1;
                win_grp = GW'(g);
                rr_idx  = IDX_W'(g * GROUP_SZ) + IDX_W'(grp_sel[g]);
            end
        end
    end

    assign cand_hit = rot_mode ? rr_hit : fix_hit;
    assign cand_idx = rot_mode ? rr_idx : fix_idx;
    assign issue    = (state_q == ST_IDLE) && en && cand_hit;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en && cand_hit) state_d = ST_HOLD;
            ST_HOLD: if (grant_done)     state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else if (issue) begin
            grant_q <= NUM_CH'(1) << cand_idx;
        end else if ((state_q == ST_HOLD) && grant_done) begin
            grant_q <= '0;
        end
    end

    assign grant     = grant_q;
    assign grant_vld = (state_q == ST_HOLD);

endmodule

// File: rtl/dma_prio_arb_sva.sv
module dma_prio_arb_sva #(
    parameter int NUM_CH = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        en,
    input logic [1:0]                  mode,
    input logic [NUM_CH-1:0]           req,
    input logic [$clog2(NUM_CH+1)-1:0] n_present,
    input logic                        grant_done,
    input logic [NUM_CH-1:0]           grant,
    input logic                        grant_vld
);

    localparam logic [NUM_CH-1:0] ALL_ONE = {NUM_CH{1'b1}};

    logic [NUM_CH-1:0] present_mask;
    assign present_mask = ~(ALL_ONE << n_present);

    assert_lowest_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_vld) && $past(mode) == 2'd0)
            |-> (((grant - NUM_CH'(1)) & $past(req) & $past(present_mask)) == '0));

    assert_upper_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_vld) && $past(mode) == 2'd3 && ($past(req & present_mask) & NUM_CH'(4'hF)) != '0)
            |-> ((grant & NUM_CH'(4'hF)) != '0));

    assert_only_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld) |-> ((grant & ~$past(present_mask)) == '0 && (grant & $past(req)) != '0));

    assert_no_grant_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld) |-> $past(en));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !grant_done) |=> (grant_vld && $stable(grant) && $onehot0(grant) && grant != '0));

    assert_release_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_done) |=> !grant_vld);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (grant == '0));

endmodule

bind dma_prio_arb dma_prio_arb_sva #(.NUM_CH(NUM_CH)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .mode       (mode),
    .req        (req),
    .n_present  (n_present),
    .grant_done (grant_done),
    .grant      (grant),
    .grant_vld  (grant_vld)
);

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb;

    localparam int NUM_CH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b1;
    logic [1:0]       mode = 2'd0;
    logic [NUM_CH-1:0] req = '0;
    logic [3:0]       n_present = 4'd6;
    logic             grant_done = 1'b0;
    logic [NUM_CH-1:0] grant;
    logic             grant_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_prio_arb #(.NUM_CH(NUM_CH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode       (mode),
        .req        (req),
        .n_present  (n_present),
        .grant_done (grant_done),
        .grant      (grant),
        .grant_vld  (grant_vld)
    );

    task automatic check(input string tag, input logic exp_vld, input logic [NUM_CH-1:0] exp_g);
        n_tests++;
        if (grant_vld !== exp_vld || grant !== exp_g) begin
            n_fail++;
            $display("FAIL %s: vld=%0b grant=%02h expected vld=%0b grant=%02h",
                     tag, grant_vld, grant, exp_vld, exp_g);
        end
    endtask

    // Raise requests, check the grant one edge later, then release it.
    task automatic grant_cycle(input logic [NUM_CH-1:0] r, input logic [NUM_CH-1:0] exp_g,
                               input string tag);
        @(negedge clk); req = r;
        @(negedge clk); check(tag, 1'b1, exp_g);
        req = '0; grant_done = 1'b1;
        @(negedge clk); check({tag, " release R9"}, 1'b0, '0);
        grant_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; grant_done = 1'b0; en = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 in reset", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", 1'b0, '0);
    endtask

    task automatic t_mode0();
        mode = 2'd0; n_present = 4'd6;
        grant_cycle(8'h28, 8'h08, "R1 ch3 over ch5");
        grant_cycle(8'h3F, 8'h01, "R1 all live");
        grant_cycle(8'h30, 8'h10, "R1 ch4 over ch5");
    endtask

    task automatic t_mode1();
        mode = 2'd1; n_present = 4'd6;
        grant_cycle(8'h22, 8'h02, "R2 ch1 over ch5");
        grant_cycle(8'h3A, 8'h08, "R2 ch3 over ch1");
        grant_cycle(8'h30, 8'h10, "R2 ch4 over ch5");
    endtask

    task automatic t_mode2();
        mode = 2'd2; n_present = 4'd6;
        grant_cycle(8'h0B, 8'h01, "R3 ch0 over ch1");
        grant_cycle(8'h06, 8'h04, "R3 ch2 first");
        grant_cycle(8'h3A, 8'h02, "R3 ch1 over ch3");
        grant_cycle(8'h30, 8'h10, "R3 ch4 over ch5");
    endtask

    task automatic t_present();
        n_present = 4'd8;
        mode = 2'd0; grant_cycle(8'hC0, 8'h40, "R1 ch6 with eight present");
        mode = 2'd1; grant_cycle(8'hA0, 8'h80, "R2 ch7 over ch5");
        mode = 2'd2; grant_cycle(8'hA0, 8'h20, "R3 ch5 over ch7");
        n_present = 4'd6;
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            @(negedge clk); req = 8'hC0;
            @(negedge clk); check("R6 ch6/7 masked", 1'b0, '0);
            @(negedge clk); check("R6 ch6/7 still masked", 1'b0, '0);
            req = '0;
        end
        mode = 2'd2; grant_cycle(8'hE0, 8'h20, "R6 ch5 wins over masked");
    endtask

    task automatic t_rotate();
        do_reset();
        mode = 2'd3; n_present = 4'd6;
        grant_cycle(8'h0F, 8'h01, "R5 upper turn 0");
        grant_cycle(8'h0F, 8'h02, "R5 upper turn 1");
        grant_cycle(8'h0F, 8'h04, "R5 upper turn 2");
        grant_cycle(8'h0F, 8'h08, "R5 upper turn 3");
        grant_cycle(8'h0F, 8'h01, "R5 upper wrap");
        grant_cycle(8'h31, 8'h01, "R4 upper beats lower");
        grant_cycle(8'h30, 8'h10, "R5 lower turn ch4");
        grant_cycle(8'h30, 8'h20, "R5 lower turn ch5");
        grant_cycle(8'hF0, 8'h10, "R5 lower wrap past masked");
        grant_cycle(8'h05, 8'h04, "R5 upper from pointer 1");
        grant_cycle(8'h05, 8'h01, "R5 upper wrap from pointer 3");
    endtask

    task automatic t_enable();
        mode = 2'd0; n_present = 4'd6;
        @(negedge clk); en = 1'b0; req = 8'h01;
        @(negedge clk); check("R7 disabled", 1'b0, '0);
        @(negedge clk); check("R7 still disabled", 1'b0, '0);
        en = 1'b1;
        @(negedge clk); check("R7 enabled grant", 1'b1, 8'h01);
        req = '0; grant_done = 1'b1;
        @(negedge clk); grant_done = 1'b0;
    endtask

    task automatic t_hold();
        mode = 2'd0; n_present = 4'd6;
        @(negedge clk); req = 8'h20;
        @(negedge clk); check("R8 first grant", 1'b1, 8'h20);
        req = 8'h01;
        @(negedge clk); check("R8 held vs higher request", 1'b1, 8'h20);
        mode = 2'd2; en = 1'b0;
        @(negedge clk); check("R8 held with en low", 1'b1, 8'h20);
        mode = 2'd0; en = 1'b1;
        @(negedge clk); check("R8 held again", 1'b1, 8'h20);
        grant_done = 1'b1;
        @(negedge clk); check("R9 gap after done", 1'b0, '0);
        grant_done = 1'b0;
        @(negedge clk); check("R9 rearbitrated", 1'b1, 8'h01);
        req = '0; grant_done = 1'b1;
        @(negedge clk); grant_done = 1'b0;
    endtask

    task automatic t_idle();
        mode = 2'd3; req = '0;
        repeat (3) begin
            @(negedge clk); check("R10 no request", 1'b0, '0);
        end
    endtask

    initial begin
        do_reset();
        t_idle();
        t_mode0();
        t_mode1();
        t_mode2();
        t_present();
        t_enable();
        t_hold();
        t_rotate();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule